// File: doc/BRIEF.md
# Serial Register Target with Command Strobe

This block is the target end of a four-wire bit-serial register link, as used by a board-control logic device. The initiator drives a serial clock, a data line into the block and an active-low strobe; the block answers on a data line back to the initiator. No chip select frames a transfer. Address and data bits stream in one after another. A single clock pulse taken while the strobe is low is the command cycle, and the data bit seen in that cycle chooses between a read and a write.

All three incoming wires pass through two-flop synchronisers into the system clock, and their edges are found there. The serial clock must therefore stay in each phase for several system clocks. Behind the link sits a small register file. It holds two read/write control words, which are also driven out as ports. It has an 8-bit switch input shown as a read-only word and a constant version word. A reset-request location turns a written 1 into a single system-clock pulse.

Top module: `sreg_target`

## Requirements
- R1: A read is 8 address bits, then a command cycle with data-in 0, then 32 clock pulses on which the register value appears on serOut, most-significant bit first. The first bit is valid before the first rising edge after the command cycle, and each later bit follows a falling edge.
- R2: A write is 32 data bits, then 8 address bits (both most-significant bit first), then a command cycle with data-in 1. A write to address 0x00 updates the mode word, which reads back and appears on modeOut.
- R3: Address 0x02 is a read/write mux word that reads back and appears on muxOut.
- R4: Address 0x08 reads the dipSw input zero-extended to 32 bits. A write there changes neither modeOut nor muxOut.
- R5: Address 0xFF reads the VERSION parameter. A write there leaves the value read back unchanged.
- R6: A read from an address outside {0x00, 0x02, 0x08, 0x80, 0xFF} returns zero. A write to such an address changes no port and no readable register.
- R7: A write to 0x80 with data bit 0 set gives exactly one system-clock pulse on resetReq. A write there with bit 0 clear gives none, and a read of 0x80 returns zero.
- R8: Only the strobed cycle commits. Any number of extra bits shifted in with the strobe high before a write are discarded, and the last 40 bits shifted decide the data and the address.
- R9: After reset, modeOut and muxOut are zero and serOut and resetReq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial clock from the initiator |
| strobeN | input | 1 | Active-low command strobe |
| serIn | input | 1 | Serial data into the block |
| serOut | output | 1 | Serial read data to the initiator |
| dipSw | input | DIP_W | Switch bank shown at address 0x08 |
| modeOut | output | DATA_W | Mode word |
| muxOut | output | DATA_W | Mux word |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
The hardest condition to reach is a command cycle that arrives after a long, unaligned run of stray bits. Here the block has to frame the transaction from the last 40 bits alone. The stimulus creates this by clocking a random number of random prefix bits with the strobe high before a write, then reading the target back. A second hard case is the output bit that must not shift on the falling edge of the command cycle. The bench reaches it through reads whose register values have random top bits, so that a lost or doubled first bit shows up at once.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_MUX  = 8'h02;
  localparam logic [ADDR_W-1:0] ADDR_DIP  = 8'h08;
  localparam logic [ADDR_W-1:0] ADDR_RST  = 8'h80;
  localparam logic [ADDR_W-1:0] ADDR_VER  = 8'hFF;

  // strobes from control to datapath, each valid for one system clock
  typedef struct packed {
    logic bitIn;     // synchronised serial data bit
    logic shiftIn;   // rising serial clock, strobe inactive
    logic commitWr;  // command cycle, write
    logic loadRd;    // command cycle, read
    logic shiftOut;  // falling serial clock outside the command cycle
  } ctrl_t;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/sreg_ctrl.sv
module sreg_ctrl import sreg_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  serClk,
  input  logic  strobeN,
  input  logic  serIn,
  output ctrl_t ctrl
);
  logic [2:0] rawIn;
  logic [2:0] syncOut;
  logic sckS, strbNS, dinS;
  logic sckPrev;
  logic cmdSeen;
  logic sckRise, sckFall;

  assign rawIn = {serClk, strobeN, serIn};

  sreg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
    .clk(clk), .rstN(rstN), .din(rawIn), .dout(syncOut)
  );

  assign {sckS, strbNS, dinS} = syncOut;
  assign sckRise = sckS & ~sckPrev;
  assign sckFall = ~sckS & sckPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      cmdSeen <= 1'b0;
    end else begin
      sckPrev <= sckS;
      if (sckRise && !strbNS) cmdSeen <= 1'b1;
      else if (sckFall)       cmdSeen <= 1'b0;
    end
  end

  always_comb begin
    ctrl.bitIn    = dinS;
    ctrl.shiftIn  = sckRise & strbNS;
    ctrl.commitWr = sckRise & ~strbNS & dinS;
    ctrl.loadRd   = sckRise & ~strbNS & ~dinS;
    ctrl.shiftOut = sckFall & ~cmdSeen;
  end

  // the command cycle and the output shifting happen on opposite serial edges
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.shiftIn, ctrl.commitWr, ctrl.loadRd, ctrl.shiftOut})); // R8
  // one command edge commits at most once
  AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.commitWr |=> !ctrl.commitWr); // R8
  // the falling edge that closes a command cycle never shifts read data
  AST_CMD_NO_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadRd || ctrl.commitWr) |=> !ctrl.shiftOut); // R1
endmodule

// File: rtl/sreg_datapath.sv
module sreg_datapath import sreg_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int DIP_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] VERSION = 32'h0000_0103
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [DIP_W-1:0]  dipSw,
  output logic              serOut,
  output logic [DATA_W-1:0] modeOut,
  output logic [DATA_W-1:0] muxOut,
  output logic              resetReq
);
  localparam int FRAME_W = DATA_W + ADDR_W;

  logic [FRAME_W-1:0] inShift;
  logic [ADDR_W-1:0]  addrFld;
  logic [DATA_W-1:0]  wrData;
  logic [DATA_W-1:0]  outShift;
  logic [DATA_W-1:0]  rdData;
  logic [DATA_W-1:0]  modeReg, muxReg;
  logic [DIP_W-1:0]   dipS;
  logic               rstBit;

  sreg_sync #(.WIDTH(DIP_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_dipSync (
    .clk(clk), .rstN(rstN), .din(dipSw), .dout(dipS)
  );

  assign addrFld = inShift[ADDR_W-1:0];
  assign wrData  = inShift[FRAME_W-1:ADDR_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inShift <= '0;
    else if (ctrl.shiftIn) inShift <= {inShift[FRAME_W-2:0], ctrl.bitIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= '0;
      muxReg   <= '0;
      rstBit   <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      if (ctrl.commitWr && addrFld == ADDR_MODE) modeReg <= wrData;
      if (ctrl.commitWr && addrFld == ADDR_MUX)  muxReg  <= wrData;
      rstBit   <= ctrl.commitWr && (addrFld == ADDR_RST) && wrData[0];
      resetReq <= rstBit;
    end
  end

  always_comb begin
    case (addrFld)
      ADDR_MODE: rdData = modeReg;
      ADDR_MUX:  rdData = muxReg;
      ADDR_DIP:  rdData = DATA_W'(dipS);
      ADDR_RST:  rdData = DATA_W'(rstBit);
      ADDR_VER:  rdData = VERSION;
      default:   rdData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outShift <= '0;
    else if (ctrl.loadRd) outShift <= rdData;
    else if (ctrl.shiftOut) outShift <= {outShift[DATA_W-2:0], 1'b0};
  end

  assign serOut  = outShift[DATA_W-1];
  assign modeOut = modeReg;
  assign muxOut  = muxReg;

  AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq); // R7
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.commitWr |=> $stable(modeReg)); // R2
  AST_MUX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.commitWr |=> $stable(muxReg)); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadRd && addrFld != ADDR_MODE && addrFld != ADDR_MUX &&
     addrFld != ADDR_DIP && addrFld != ADDR_RST && addrFld != ADDR_VER)
    |=> (outShift == '0)); // R6
endmodule

// File: rtl/sreg_target.sv
module sreg_target import sreg_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int DIP_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] VERSION = 32'h0000_0103
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              strobeN,
  input  logic              serIn,
  output logic              serOut,
  input  logic [DIP_W-1:0]  dipSw,
  output logic [DATA_W-1:0] modeOut,
  output logic [DATA_W-1:0] muxOut,
  output logic              resetReq
);
  ctrl_t ctrl;

  sreg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .strobeN(strobeN),
    .serIn(serIn), .ctrl(ctrl)
  );

  sreg_datapath #(.DATA_W(DATA_W), .DIP_W(DIP_W), .SYNC_STAGES(SYNC_STAGES),
                  .VERSION(VERSION)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .dipSw(dipSw), .serOut(serOut),
    .modeOut(modeOut), .muxOut(muxOut), .resetReq(resetReq)
  );
endmodule

// File: tb/test_sreg_target.sv
module test_sreg_target;
  localparam int HALF = 8;
  localparam logic [31:0] VER = 32'h0000_0103;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, strobeN = 1'b1, serIn = 1'b0;
  logic serOut, resetReq;
  logic [7:0] dipSw = 8'h00;
  logic [31:0] modeOut, muxOut;

  int checks = 0, fails = 0, pulseCnt = 0;
  logic [31:0] mMode = '0, mMux = '0;

  always #10 clk = ~clk;

  sreg_target #(.VERSION(VER)) i_sreg_target (
    .clk(clk), .rstN(rstN), .serClk(serClk), .strobeN(strobeN), .serIn(serIn),
    .serOut(serOut), .dipSw(dipSw), .modeOut(modeOut), .muxOut(muxOut),
    .resetReq(resetReq)
  );

  always @(posedge clk) if (resetReq) pulseCnt++;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a)
      8'h00: return mMode;
      8'h02: return mMux;
      8'h08: return {24'h0, dipSw};
      8'hFF: return VER;
      default: return 32'h0;
    endcase
  endfunction

  task automatic pulseBit(input logic b);
    @(negedge clk); serIn = b;
    repeat (HALF) @(negedge clk);
    serClk = 1'b1;
    repeat (HALF) @(negedge clk);
    serClk = 1'b0;
  endtask

  task automatic cmdBit(input logic b);
    @(negedge clk); strobeN = 1'b0;
    pulseBit(b);
    @(negedge clk); strobeN = 1'b1;
  endtask

  task automatic serWrite(input logic [7:0] a, input logic [31:0] d);
    for (int i = 31; i >= 0; i--) pulseBit(d[i]);
    for (int i = 7; i >= 0; i--) pulseBit(a[i]);
    cmdBit(1'b1);
    repeat (HALF) @(negedge clk);
  endtask

  task automatic serRead(input logic [7:0] a, output logic [31:0] d);
    for (int i = 7; i >= 0; i--) pulseBit(a[i]);
    cmdBit(1'b0);
    for (int i = 31; i >= 0; i--) begin
      repeat (HALF) @(negedge clk);
      d[i] = serOut;
      serClk = 1'b1;
      repeat (HALF) @(negedge clk);
      serClk = 1'b0;
    end
  endtask

  initial begin
    logic [31:0] rd, d;
    logic [7:0] a;
    int p0;
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 modeOut", modeOut, 0);
    check("R9 muxOut", muxOut, 0);
    check("R9 serOut", {31'b0, serOut}, 0);
    check("R9 resetReq", {31'b0, resetReq}, 0);

    serRead(8'hFF, rd); check("R5 version", rd, VER);
    serWrite(8'h00, 32'h8000_0001); mMode = 32'h8000_0001;
    check("R2 modeOut", modeOut, mMode);
    serRead(8'h00, rd); check("R2 mode readback", rd, mMode);
    serWrite(8'h02, 32'hA5C3_0F96); mMux = 32'hA5C3_0F96;
    check("R3 muxOut", muxOut, mMux);
    serRead(8'h02, rd); check("R3 mux readback", rd, mMux);
    dipSw = 8'hB7;
    serRead(8'h08, rd); check("R4 dip read", rd, 32'h0000_00B7);
    serWrite(8'h08, 32'hFFFF_FFFF);
    check("R4 mode kept", modeOut, mMode); check("R4 mux kept", muxOut, mMux);
    serWrite(8'hFF, 32'h1234_5678);
    serRead(8'hFF, rd); check("R5 version after write", rd, VER);
    serWrite(8'h41, 32'hDEAD_BEEF);
    check("R6 mode kept", modeOut, mMode); check("R6 mux kept", muxOut, mMux);
    serRead(8'h41, rd); check("R6 unmapped read", rd, 0);

    p0 = pulseCnt;
    serWrite(8'h80, 32'h0000_0001);
    check("R7 one pulse", pulseCnt - p0, 1);
    serWrite(8'h80, 32'hFFFF_FFFE);
    check("R7 no pulse on bit0 clear", pulseCnt - p0, 1);
    serRead(8'h80, rd); check("R7 reset reads zero", rd, 0);

    for (int k = 0; k < 4; k++) begin
      int n = 1 + ($urandom % 45);
      for (int j = 0; j < n; j++) pulseBit(1'($urandom));
      d = $urandom;
      serWrite(8'h00, d); mMode = d;
      serRead(8'h00, rd); check("R8 prefix bits discarded", rd, mMode);
    end

    for (int k = 0; k < 24; k++) begin
      case ($urandom % 6)
        0: a = 8'h00; 1: a = 8'h02; 2: a = 8'h08;
        3: a = 8'hFF; 4: a = 8'h80; default: a = 8'($urandom);
      endcase
      d = $urandom;
      dipSw = 8'($urandom);
      if ($urandom % 2) begin
        p0 = pulseCnt;
        serWrite(a, d);
        if (a == 8'h00) mMode = d;
        if (a == 8'h02) mMux = d;
        check("R2/R3 modeOut random", modeOut, mMode);
        check("R2/R3 muxOut random", muxOut, mMux);
        check("R7 pulse random", pulseCnt - p0, (a == 8'h80) ? {31'b0, d[0]} : 0);
      end else begin
        serRead(a, rd);
        check("R1 random read", rd, expRead(a));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule